// File: doc/BRIEF.md
# Fibonacci Pseudorandom Bit Generator

This block produces a serial pseudorandom bit stream from a shift register whose feedback is the GF(2) sum of a chosen set of its own stages. The set of contributing stages comes from a coefficient mask parameter, and the start value comes from a seed parameter. In the default build the register is five stages long, its mask is `5'b00101`, and it steps through a maximal-length cycle of 31 states.

On every clock with the enable high, the register moves one place toward bit 0. The vacated top bit takes the XOR of the stages selected by the mask. Bit 0 is the serial output, and the whole register is also visible at the ports. A synchronous reset loads the seed. Choosing another nonzero seed only changes where in the same cycle the stream begins.

Top module: `lfsr_gen`

## Requirements
- R1: A clock edge with `rst` high loads `state` with `SEED`. The default seed is `5'b00001`.
- R2: A clock edge with `rst` low and `en` high sets new `state[W-2:0]` to old `state[W-1:1]`. New `state[W-1]` is the XOR of the old bits selected by ones in `TAP_MASK`. With the default mask, these are bits 0 and 2.
- R3: With the default mask, state `00001` is followed by `10000`.
- R4: With the default mask, state `00100` is followed by `10010`, and `10010` is followed by `01001`.
- R5: When both default tapped bits are 1, the new top bit is 0. For example, `01101` is followed by `00110`.
- R6: A clock edge with `rst` low and `en` low leaves `state` unchanged.
- R7: `out_bit` always equals `state[0]`.
- R8: With the default mask, 31 enabled steps after reset return `state` to the seed. Those 31 states are all distinct and nonzero.
- R9: Over one 31-step period with the default mask, `out_bit` is 1 in exactly 16 of the states.
- R10: Reset takes priority over the enable. A reset edge with `en` high still loads the seed.
- R11: A generator seeded with another nonzero value, here `5'b01101`, visits the same cycle as the default one. It is offset to the position where that value occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the seed |
| en | input | 1 | Step enable; low holds the register |
| out_bit | output | 1 | Serial pseudorandom output (bit 0 of the register) |
| state | output | W | Full register contents |

## Verification
The assertions assume the register has seen at least one reset before they apply. The nonzero-state and stepping properties are therefore gated until the first reset edge, and the stimulus always begins with reset held for two cycles. They also assume a nonzero seed, which every instance in the bench uses. Within that envelope the stimulus mixes long enabled runs, isolated stalls, and a reset asserted together with the enable. This exercises every branch of the step selection.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    localparam int          DEF_WIDTH = 5;
    localparam logic [4:0]  DEF_TAPS  = 5'b00101;
    localparam logic [4:0]  DEF_SEED  = 5'b00001;

    // What the register does on the next edge
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_LOAD  = 2'd1,
        STEP_SHIFT = 2'd2
    } step_e;

    // Reset outranks the enable
    function automatic step_e step_select(input logic rst, input logic en);
        if (rst)
            return STEP_LOAD;
        else if (en)
            return STEP_SHIFT;
        else
            return STEP_HOLD;
    endfunction

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
    parameter int             W        = 5,
    parameter logic [W-1:0]   TAP_MASK = 5'b00101
) (
    input  logic [W-1:0] cur,
    output logic         fb
);
    // Running GF(2) sum; a zero coefficient reduces a stage to a pass-through
    logic [W:0] acc;

    assign acc[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_tap
            assign acc[i+1] = acc[i] ^ (cur[i] & TAP_MASK[i]);
        end
    endgenerate

    assign fb = acc[W];
endmodule

// File: rtl/lfsr_step.sv
module lfsr_step
    import lfsr_pkg::*;
#(
    parameter int             W    = 5,
    parameter logic [W-1:0]   SEED = 5'b00001
) (
    input  step_e        op,
    input  logic [W-1:0] cur,
    input  logic         fb,
    output logic [W-1:0] nxt
);
    always_comb begin
        unique case (op)
            STEP_LOAD:  nxt = SEED;
            STEP_SHIFT: nxt = {fb, cur[W-1:1]};
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen
    import lfsr_pkg::*;
#(
    parameter int             W        = DEF_WIDTH,
    parameter logic [W-1:0]   TAP_MASK = DEF_TAPS,
    parameter logic [W-1:0]   SEED     = DEF_SEED
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic         out_bit,
    output logic [W-1:0] state
);
    logic [W-1:0] reg_q;
    logic [W-1:0] reg_d;
    logic         fb;
    step_e        op;

    assign op = step_select(rst, en);

    lfsr_feedback #(.W(W), .TAP_MASK(TAP_MASK)) u_fb (
        .cur (reg_q),
        .fb  (fb)
    );

    lfsr_step #(.W(W), .SEED(SEED)) u_step (
        .op  (op),
        .cur (reg_q),
        .fb  (fb),
        .nxt (reg_d)
    );

    always_ff @(posedge clk) begin
        reg_q <= reg_d;
    end

    assign state   = reg_q;
    assign out_bit = reg_q[0];
endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk #(
    parameter int             W        = 5,
    parameter logic [W-1:0]   TAP_MASK = 5'b00101,
    parameter logic [W-1:0]   SEED     = 5'b00001
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [W-1:0] state
);
    // Set by the first reset edge; properties are meaningless before it
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    // R1
    a_r1_reset_load: assert property (@(posedge clk) disable iff (!armed)
        rst |=> (state == SEED));

    // R2: lower bits move down one place
    a_r2_shift_down: assert property (@(posedge clk) disable iff (rst || !armed)
        en |=> (state[W-2:0] == $past(state[W-1:1])));

    // R2: top bit takes the masked parity of the previous value
    a_r2_top_parity: assert property (@(posedge clk) disable iff (rst || !armed)
        en |=> (state[W-1] == ^($past(state) & TAP_MASK)));

    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (rst || !armed)
        !en |=> $stable(state));

    // R8: the all-zero lock-up state is never reached from a nonzero seed
    a_r8_nonzero: assert property (@(posedge clk) disable iff (rst || !armed)
        1'b1 |-> (state != '0));
endmodule

bind lfsr_gen lfsr_gen_chk #(.W(W), .TAP_MASK(TAP_MASK), .SEED(SEED)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .state (state)
);

// File: tb/lfsr_gen_test.sv
module lfsr_gen_test;
    localparam int         W     = 5;
    localparam logic [4:0] TAPS  = 5'b00101;
    localparam logic [4:0] SEED  = 5'b00001;
    localparam logic [4:0] SEED2 = 5'b01101;

    typedef struct {
        logic [4:0] exp;
        logic [4:0] exp_alt;
        string      tag;
        int         rec;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       en  = 1'b0;
    logic       out_bit, out_alt;
    logic [4:0] state, state_alt;

    int checks   = 0;
    int failures = 0;

    item_t      q[$];
    logic [4:0] obs     [0:31];
    logic [4:0] obs_alt [0:31];
    logic [4:0] m_s, m_alt;

    always #5 clk = ~clk;

    lfsr_gen #(.W(W), .TAP_MASK(TAPS), .SEED(SEED)) uut (
        .clk(clk), .rst(rst), .en(en), .out_bit(out_bit), .state(state));

    lfsr_gen #(.W(W), .TAP_MASK(TAPS), .SEED(SEED2)) uut_alt (
        .clk(clk), .rst(rst), .en(en), .out_bit(out_alt), .state(state_alt));

    function automatic logic [4:0] model_next(input logic [4:0] s);
        return {^(s & TAPS), s[4:1]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [4:0] act,
                         input logic [4:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: called at a falling edge, applies inputs, queues the expectation
    task automatic drive(input bit r, input bit e, input int rec);
        item_t it;
        string tg;
        rst = r;
        en  = e;
        if (r) begin
            tg = e ? "R10" : "R1";
            m_s = SEED;
            m_alt = SEED2;
        end else if (e) begin
            if (m_s == 5'b00001)                      tg = "R3";
            else if (m_s == 5'b00100 || m_s == 5'b10010) tg = "R4";
            else if (m_s[0] && m_s[2])                tg = "R5";
            else                                      tg = "R2";
            m_s = model_next(m_s);
            m_alt = model_next(m_alt);
        end else begin
            tg = "R6";
        end
        it.exp = m_s; it.exp_alt = m_alt; it.tag = tg; it.rec = rec;
        q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: samples shortly after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(state == it.exp, it.tag, state, it.exp);
            check(state_alt == it.exp_alt, {it.tag, " alt"}, state_alt, it.exp_alt);
            check(out_bit == it.exp[0], "R7", {4'b0, out_bit}, {4'b0, it.exp[0]});
            if (it.rec >= 0) begin
                obs[it.rec]     = state;
                obs_alt[it.rec] = state_alt;
            end
        end
    end

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ones;
        int k;
        bit seen [0:31];
        m_s = SEED;
        m_alt = SEED2;
        @(negedge clk);
        drive(1, 0, -1);
        drive(1, 0, 0);
        // one full period, recorded
        for (int n = 1; n <= 31; n++) drive(0, 1, n);
        // stalls interleaved with steps
        drive(0, 0, -1);
        drive(0, 0, -1);
        drive(0, 1, -1);
        drive(0, 0, -1);
        for (int n = 0; n < 7; n++) drive(0, (n % 2) == 0, -1);
        // reset while enabled, then resume
        drive(1, 1, -1);
        for (int n = 0; n < 40; n++) drive(0, (n % 5) != 3, -1);
        drive(0, 0, -1);
        @(negedge clk);

        // R8: back to the seed, all distinct and nonzero
        check(obs[31] == SEED, "R8 return", obs[31], SEED);
        for (int n = 0; n < 32; n++) seen[n] = 1'b0;
        for (int n = 0; n < 31; n++) begin
            check(obs[n] != 5'd0 && !seen[obs[n]], "R8 distinct", obs[n], 5'd0);
            seen[obs[n]] = 1'b1;
        end
        // R9: ones over one period
        ones = 0;
        for (int n = 0; n < 31; n++) ones += obs[n][0];
        check(ones == 16, "R9", ones[4:0], 5'd16);
        // R11: alternate seed is the same cycle, offset
        k = -1;
        for (int n = 0; n < 31; n++) if (obs[n] == SEED2) k = n;
        check(k >= 0, "R11 locate", SEED2, SEED2);
        if (k >= 0)
            for (int n = 0; n < 31; n++)
                check(obs_alt[n] == obs[(k + n) % 31], "R11", obs_alt[n], obs[(k + n) % 31]);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule